// File: doc/BRIEF.md
# Serial NOR Flash Software-Driven Bridge

This block lets software drive a serial NOR flash one byte at a time through memory-mapped accesses. Each attached chip has a control register and a data window in the address map. A shared configuration register holds one write-enable bit per chip. When a chip is switched to user mode and its enable bit is set, each bus write into that chip's window sends the written bytes out on a single-bit SPI bus. Each bus read clocks bytes in and returns them.

The address offset inside the window has no effect, so the window works as a FIFO. Chip select is driven entirely by a stop bit that software sets and clears. Once chip select is released, a programmable minimum high time must pass before it can be asserted again. The bus side holds `bus_ready` low until every bit of an access has been shifted. For this reason a driver can issue an opcode, an address, dummy bytes and data as a plain series of loads and stores.

Top module: `spi_user_bridge`

## Requirements
- R1: The configuration register sits at offset 0x00 and holds chip n's write-enable at bit 16+n. Every other bit of it reads back as 0. Chip n's control register sits at offset 0x10+4n. Its fields are: mode in [1:0] (3 = user), stop in [2], clock-mode-3 select in [4], LSB-first in [5] and the inactive-time code in [27:24]. All other bits read back as 0. Windows start at bus address bit 15 set, and bit 12 selects the chip.
- R2: A chip's `spi_cs_n` goes low only when its control register holds user mode with stop clear. Setting stop, or leaving user mode, drives it high again.
- R3: After `spi_cs_n` rises, it stays high for at least 16 minus the inactive-time code bus clocks. Code 0 gives 16 and code 15 gives 1. When software clears stop in time, the high time is exactly that length.
- R4: A permitted window write shifts its bytes starting with the lowest-addressed byte lane and moving upward. Address bits above the access alignment are ignored.
- R5: A permitted window read places each received byte in its own byte lane, and the remaining lanes read 0. All-ones bytes go out on `spi_mosi` during a read.
- R6: `bus_ready` is a single-cycle pulse. For a window transfer it comes only after all 8 bits of every byte have been clocked.
- R7: Bits go out and come in MSB first by default, and LSB first when the LSB-first bit is set.
- R8: Idle `spi_sclk` is low in clock mode 0 and high in clock mode 3. Data is sampled on the rising edge, and each clock phase lasts HALF_DIV bus clocks.
- R9: A window access is dropped when the chip's write-enable bit is clear or the chip is not in user mode. A dropped write makes no clock edges, and a dropped read returns 0.
- R10: A window access whose size code is 3, or whose address is not aligned to its size (size codes 0, 1 and 2 mean 1, 2 and 4 bytes), is dropped in the same way.
- R11: After reset, every `spi_cs_n` is high, `spi_sclk` is low and `bus_ready` is low. Every control register reads 0x00000004 and the configuration register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access complete pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the bridge with NUM_CS = 2 and HALF_DIV = 2. With a second chip present, the bench can reach the enable bit at position 17 and the window-select address bit. It can also check that one chip's enable bit does not gate another chip. A half period of two clocks exercises the phase divider, so the stall length depends on it.

// File: rtl/spi_user_pkg.sv
package spi_user_pkg;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_USER   = 2'd3;
  localparam int         CFG_WE_LSB  = 16;

  typedef struct packed {
    logic [3:0] inact;
    logic       lsb;
    logic       mode3;
    logic       stop;
    logic [1:0] mode;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{4'd0, 1'b0, 1'b0, 1'b1, MODE_NORMAL};

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} seq_state_t;

  function automatic ctl_t ctl_from_word(input logic [31:0] w);
    ctl_t c;
    c.inact = w[27:24];
    c.lsb   = w[5];
    c.mode3 = w[4];
    c.stop  = w[2];
    c.mode  = w[1:0];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c);
    return {4'b0, c.inact, 18'b0, c.lsb, c.mode3, 1'b0, c.stop, c.mode};
  endfunction

endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       lsb_first,
  input  logic       idle_high,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          half_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      div_q   <= '0;
      sh_q    <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          half_q <= 1'b0;
          bit_q  <= '0;
          div_q  <= '0;
          sh_q   <= tx_byte;
        end
      end else if (div_q != DIV_LAST) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!half_q) begin
          half_q  <= 1'b1;
          rx_byte <= lsb_first ? {miso, rx_byte[7:1]} : {rx_byte[6:0], miso};
        end else begin
          half_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= lsb_first ? (sh_q >> 1) : (sh_q << 1);
          end
        end
      end
    end
  end

  assign mosi = lsb_first ? sh_q[0] : sh_q[7];
  assign sclk = busy ? half_q : idle_high;

endmodule

// File: rtl/spi_user_regs.sv
module spi_user_regs
  import spi_user_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic                   ctl_wr,
  input  logic [CS_W-1:0]        ctl_idx,
  input  logic [31:0]            wdata,
  output logic [NUM_CS-1:0]      we_en,
  output ctl_t [NUM_CS-1:0]      ctl,
  output logic [NUM_CS-1:0]      cs_n
);
  logic unused_wd;
  assign unused_wd = ^wdata;

  always_ff @(posedge clk) begin
    if (rst)         we_en <= '0;
    else if (cfg_wr) we_en <= wdata[CFG_WE_LSB +: NUM_CS];
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_chip
    ctl_t       ctl_r;
    logic       cs_r;
    logic [3:0] gap_r;
    logic       want;

    assign want = (ctl_r.mode == MODE_USER) && !ctl_r.stop;

    always_ff @(posedge clk) begin
      if (rst)                                   ctl_r <= CTL_RESET;
      else if (ctl_wr && ctl_idx == CS_W'(g))   ctl_r <= ctl_from_word(wdata);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cs_r  <= 1'b1;
        gap_r <= '0;
      end else if (cs_r) begin
        if (gap_r != 4'd0) gap_r <= gap_r - 1'b1;
        else if (want)     cs_r  <= 1'b0;
      end else if (!want) begin
        cs_r  <= 1'b1;
        gap_r <= ~ctl_r.inact;
      end
    end

    assign ctl[g]  = ctl_r;
    assign cs_n[g] = cs_r;
  end

endmodule

// File: rtl/spi_user_bridge.sv
module spi_user_bridge
  import spi_user_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int AW       = 16,
  parameter int WIN_AW   = 12,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [CS_W:0] NUM_CS_V = NUM_CS[CS_W:0];

  logic unused_addr;
  assign unused_addr = ^bus_addr;

  logic [NUM_CS-1:0] we_en;
  ctl_t [NUM_CS-1:0] ctl_q;

  seq_state_t     st;
  logic [31:0]    tx_word;
  logic [1:0]     lane;
  logic [1:0]     left;
  logic [CS_W-1:0] cur_cs;
  logic           op_rd;

  logic           acc, is_win, is_cfg, is_ctl, aligned, win_ok, permit;
  logic [5:0]     reg_word, ctl_off;
  logic [CS_W-1:0] win_cs;
  logic [31:0]    reg_rd;
  logic [1:0]     n_left;

  always_comb begin
    acc      = bus_valid && (st == ST_IDLE) && !bus_ready;
    is_win   = bus_addr[AW-1];
    reg_word = bus_addr[7:2];
    ctl_off  = reg_word - 6'd4;
    is_cfg   = !is_win && (bus_addr[7:0] == 8'd0);
    is_ctl   = !is_win && (bus_addr[1:0] == 2'd0) && (reg_word >= 6'd4) &&
               (ctl_off < 6'(NUM_CS));
    win_cs   = bus_addr[WIN_AW +: CS_W];
    win_ok   = {1'b0, win_cs} < NUM_CS_V;
    case (bus_size)
      2'd0:    begin aligned = 1'b1;                   n_left = 2'd0; end
      2'd1:    begin aligned = !bus_addr[0];           n_left = 2'd1; end
      2'd2:    begin aligned = (bus_addr[1:0] == 2'd0); n_left = 2'd3; end
      default: begin aligned = 1'b0;                   n_left = 2'd0; end
    endcase
    permit = is_win && win_ok && aligned &&
             (ctl_q[win_cs].mode == MODE_USER) && we_en[win_cs];
    if (is_cfg)      reg_rd = 32'(we_en) << CFG_WE_LSB;
    else if (is_ctl) reg_rd = ctl_to_word(ctl_q[ctl_off[CS_W-1:0]]);
    else             reg_rd = '0;
  end

  spi_user_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (acc && bus_write && is_cfg),
    .ctl_wr  (acc && bus_write && is_ctl),
    .ctl_idx (ctl_off[CS_W-1:0]),
    .wdata   (bus_wdata),
    .we_en   (we_en),
    .ctl     (ctl_q),
    .cs_n    (spi_cs_n)
  );

  logic       shift_busy, shift_done;
  logic [7:0] rx_byte;

  spi_bit_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (st == ST_LAUNCH),
    .tx_byte   (op_rd ? 8'hFF : tx_word[{lane, 3'b000} +: 8]),
    .lsb_first (ctl_q[cur_cs].lsb),
    .idle_high (ctl_q[cur_cs].mode3),
    .miso      (spi_miso),
    .busy      (shift_busy),
    .done      (shift_done),
    .rx_byte   (rx_byte),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
      tx_word   <= '0;
      lane      <= '0;
      left      <= '0;
      cur_cs    <= '0;
      op_rd     <= 1'b0;
    end else begin
      bus_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (acc) begin
            if (is_win && permit) begin
              st        <= ST_LAUNCH;
              tx_word   <= bus_wdata;
              lane      <= bus_addr[1:0];
              left      <= n_left;
              cur_cs    <= win_cs;
              op_rd     <= !bus_write;
              bus_rdata <= '0;
            end else begin
              bus_ready <= 1'b1;
              bus_rdata <= (is_win || bus_write) ? 32'd0 : reg_rd;
            end
          end
        end
        ST_LAUNCH: st <= ST_WAIT;
        ST_WAIT: begin
          if (shift_done) begin
            if (op_rd) bus_rdata[{lane, 3'b000} +: 8] <= rx_byte;
            if (left == 2'd0) begin
              bus_ready <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              lane <= lane + 1'b1;
              left <= left - 1'b1;
              st   <= ST_LAUNCH;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_user_bridge_chk.sv
module spi_user_bridge_chk
  import spi_user_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              shift_busy,
  input ctl_t [NUM_CS-1:0] ctl,
  input logic [NUM_CS-1:0] cs_n
);
  logic unused_ctl;
  assign unused_ctl = ^ctl;

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  a_r6_no_ready_while_shifting: assert property (@(posedge clk) disable iff (rst)
    shift_busy |-> !bus_ready);

  a_r6_ready_needs_request: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> $past(bus_valid));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    a_r2_cs_follows_ctl: assert property (@(posedge clk) disable iff (rst)
      !cs_n[g] |-> $past(ctl[g].mode == MODE_USER && !ctl[g].stop));
  end

endmodule

bind spi_user_bridge spi_user_bridge_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .shift_busy (shift_busy),
  .ctl        (ctl_q),
  .cs_n       (spi_cs_n)
);

// File: tb/spi_user_bridge_tb.sv
module spi_user_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, spi_sclk, spi_mosi, spi_miso;
  logic [1:0]  spi_cs_n;

  always #2 clk = ~clk;

  spi_user_bridge #(.NUM_CS(2), .AW(16), .WIN_AW(12), .HALF_DIV(2)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int n_chk = 0, n_fail = 0;
  logic [7:0] resp [4];
  bit resp_lsb = 1'b0;
  int rise_n = 0;
  bit cap [64];
  int run = 0, last_run = 0;
  bit ended = 1'b0;

  // serial flash model: record MOSI on each rising edge, feed MISO by edge count
  always @(posedge spi_sclk) begin
    if (rise_n < 64) cap[rise_n] = spi_mosi;
    rise_n = rise_n + 1;
  end
  always @* begin
    if (rise_n < 32) spi_miso = resp_lsb ? resp[rise_n/8][rise_n%8] : resp[rise_n/8][7 - rise_n%8];
    else             spi_miso = 1'b0;
  end

  always @(negedge clk) begin
    if (rst) run = 0;
    else if (spi_cs_n[0]) run = run + 1;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  function automatic logic [7:0] cap_byte(input int k, input bit lsb);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) begin
      if (lsb) v[j] = cap[k*8+j];
      else     v[7-j] = cap[k*8+j];
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ready && cyc < 5000);
    if (cyc >= 5000) chk(1'b0, "bus timeout", 32'(cyc), 32'd0);
    rd = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r; int c;
    bus(1'b1, a, 2'd2, d, r, c);
  endtask

  task automatic win(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    rise_n = 0;
    bus(wr, a, sz, wd, rd, cyc);
  endtask

  task automatic t_reset;
    logic [31:0] r; int c;
    chk(spi_cs_n == 2'b11, "R11 cs_n after reset", 32'(spi_cs_n), 32'h3);
    chk(spi_sclk == 1'b0, "R11 sclk after reset", 32'(spi_sclk), 32'h0);
    chk(bus_ready == 1'b0, "R11 ready after reset", 32'(bus_ready), 32'h0);
    bus(1'b0, 16'h0010, 2'd2, 0, r, c);
    chk(r == 32'h4, "R11 control reset value", r, 32'h4);
    bus(1'b0, 16'h0000, 2'd2, 0, r, c);
    chk(r == 32'h0, "R11 config reset value", r, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] r; int c;
    wr32(16'h0000, 32'hFFFF_FFFF);
    bus(1'b0, 16'h0000, 2'd2, 0, r, c);
    chk(r == 32'h0003_0000, "R1 config readback", r, 32'h0003_0000);
    wr32(16'h0000, 32'h0001_0000);
    wr32(16'h0010, 32'h8C00_003F);
    bus(1'b0, 16'h0010, 2'd2, 0, r, c);
    chk(r == 32'h0C00_0037, "R1 control readback", r, 32'h0C00_0037);
    chk(spi_sclk == 1'b1, "R8 mode 3 idle high", 32'(spi_sclk), 32'h1);
    chk(spi_cs_n[0] == 1'b1, "R2 stop set keeps cs high", 32'(spi_cs_n), 32'h3);
    wr32(16'h0010, 32'h0000_0007);
    chk(spi_sclk == 1'b0, "R8 mode 0 idle low", 32'(spi_sclk), 32'h0);
  endtask

  task automatic t_gap;
    wr32(16'h0010, 32'h0000_0003);
    repeat (3) @(negedge clk);
    chk(spi_cs_n[0] == 1'b0, "R2 stop clear asserts cs", 32'(spi_cs_n), 32'h2);
    wr32(16'h0010, 32'h0000_0007);
    wr32(16'h0010, 32'h0000_0003);
    repeat (24) @(negedge clk);
    chk(last_run == 16, "R3 code 0 gives 16 clocks", 32'(last_run), 32'd16);
    wr32(16'h0010, 32'h0400_0007);
    wr32(16'h0010, 32'h0400_0003);
    repeat (24) @(negedge clk);
    chk(last_run == 12, "R3 code 4 gives 12 clocks", 32'(last_run), 32'd12);
    wr32(16'h0010, 32'h0000_0003);
  endtask

  task automatic t_write;
    logic [31:0] r; int c;
    win(1'b1, 16'h8000, 2'd2, 32'h4433_2211, r, c);
    chk(rise_n == 32, "R6 four bytes clocked", 32'(rise_n), 32'd32);
    chk(c >= 128, "R6 access stalled for shifting", 32'(c), 32'd128);
    chk({cap_byte(0,0), cap_byte(1,0), cap_byte(2,0), cap_byte(3,0)} == 32'h1122_3344,
        "R4 lowest lane first", {cap_byte(0,0), cap_byte(1,0), cap_byte(2,0), cap_byte(3,0)}, 32'h1122_3344);
    @(negedge clk);
    chk(bus_ready == 1'b0, "R6 ready is one cycle", 32'(bus_ready), 32'h0);
    win(1'b1, 16'h8106, 2'd1, 32'hBEEF_0000, r, c);
    chk({cap_byte(0,0), cap_byte(1,0)} == 16'hEFBE && rise_n == 16, "R4 offset ignored",
        {8'(rise_n), 8'h0, cap_byte(0,0), cap_byte(1,0)}, 32'h1000_EFBE);
  endtask

  task automatic t_read;
    logic [31:0] r; int c;
    resp[0] = 8'hA1; resp[1] = 8'hB2; resp[2] = 8'hC3; resp[3] = 8'hD4;
    win(1'b0, 16'h8000, 2'd2, 0, r, c);
    chk(r == 32'hD4C3_B2A1, "R5 four byte read", r, 32'hD4C3_B2A1);
    chk(cap_byte(0,0) == 8'hFF && cap_byte(3,0) == 8'hFF, "R5 ones sent during read",
        {cap_byte(0,0), cap_byte(3,0)}, 32'hFFFF);
    resp[0] = 8'h5A;
    win(1'b0, 16'h8001, 2'd0, 0, r, c);
    chk(r == 32'h0000_5A00, "R5 single byte lane 1", r, 32'h0000_5A00);
  endtask

  task automatic t_order_mode;
    logic [31:0] r; int c;
    wr32(16'h0010, 32'h0000_0023);
    win(1'b1, 16'h8000, 2'd0, 32'h01, r, c);
    chk(cap[0] == 1'b1 && cap_byte(0,1) == 8'h01, "R7 lsb first write", 32'(cap_byte(0,1)), 32'h01);
    resp_lsb = 1'b1; resp[0] = 8'h80;
    win(1'b0, 16'h8000, 2'd0, 0, r, c);
    chk(r == 32'h80, "R7 lsb first read", r, 32'h80);
    resp_lsb = 1'b0;
    wr32(16'h0010, 32'h0000_0013);
    win(1'b1, 16'h8000, 2'd0, 32'h96, r, c);
    chk(cap_byte(0,0) == 8'h96 && rise_n == 8, "R8 mode 3 transfer", 32'(cap_byte(0,0)), 32'h96);
    @(negedge clk);
    chk(spi_sclk == 1'b1, "R8 mode 3 returns high", 32'(spi_sclk), 32'h1);
  endtask

  task automatic t_blocked;
    logic [31:0] r; int c;
    wr32(16'h0014, 32'h0000_0003);
    resp[0] = 8'hFF; resp[1] = 8'hFF; resp[2] = 8'hFF; resp[3] = 8'hFF;
    win(1'b1, 16'h9000, 2'd0, 32'h3C, r, c);
    chk(rise_n == 0, "R9 write dropped without enable", 32'(rise_n), 32'd0);
    win(1'b0, 16'h9000, 2'd2, 0, r, c);
    chk(r == 32'h0 && rise_n == 0, "R9 read zero without enable", r, 32'h0);
    wr32(16'h0000, 32'h0003_0000);
    win(1'b1, 16'h9000, 2'd0, 32'h3C, r, c);
    chk(rise_n == 8 && cap_byte(0,0) == 8'h3C, "R9 chip 1 enabled", 32'(cap_byte(0,0)), 32'h3C);
    chk(spi_cs_n[1] == 1'b0, "R2 chip 1 selected", 32'(spi_cs_n), 32'h0);
    wr32(16'h0010, 32'h0000_0005);
    win(1'b0, 16'h8000, 2'd2, 0, r, c);
    chk(r == 32'h0 && rise_n == 0, "R9 read outside user mode", r, 32'h0);
  endtask

  task automatic t_misaligned;
    logic [31:0] r; int c;
    wr32(16'h0010, 32'h0000_0003);
    win(1'b1, 16'h8001, 2'd1, 32'hFFFF_FFFF, r, c);
    chk(rise_n == 0, "R10 odd halfword dropped", 32'(rise_n), 32'd0);
    win(1'b0, 16'h8002, 2'd2, 0, r, c);
    chk(r == 32'h0 && rise_n == 0, "R10 misaligned word read zero", r, 32'h0);
    win(1'b1, 16'h8000, 2'd3, 32'hFFFF_FFFF, r, c);
    chk(rise_n == 0, "R10 size code 3 dropped", 32'(rise_n), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gap();
    t_write();
    t_read();
    t_order_mode();
    t_blocked();
    t_misaligned();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule